// File: doc/BRIEF.md
# Coalescing Command Byte Queue

This block sits between a producer of single-byte probe commands and the outgoing link of a remote scan-chain debugger. Instead of sending each command byte on its own, it collects the bytes in a local buffer. It then sends them as one framed burst. The frame marks its first byte with a start flag and its last byte with an end flag.

A burst leaves when one of three things happens:
- the buffer reaches its capacity;
- the producer enqueues a read request, which is a command byte with the request bit set;
- an explicit flush strobe arrives while bytes are waiting.

A read request always closes its frame, so every earlier write reaches the target before the read is serviced. After a read, the producer is held off until the single reply byte has come back on the reply input and has been handed to the producer. This means at most one read is ever outstanding.

Top module: `coalq_cmd_queue`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid`, `rd_valid` and `rsp_ready` are 0.
- R2: Command bytes with bit 7 clear (writes) are held in the buffer and produce no output until a flush condition occurs.
- R3: When the buffer holds DEPTH bytes (default 64), they leave as a single frame in arrival order. `out_sof` is set on the first byte only and `out_eof` on the last byte only.
- R4: A command byte with bit 7 set (read request) closes the current frame. That frame carries all earlier buffered bytes in order, followed by the read byte as its last byte, marked with `out_eof`.
- R5: While a frame is being sent, `in_ready` is 0. While `out_ready` is 0, `out_valid`, `out_data` and the flags hold their values.
- R6: After a read request is accepted, `in_ready` stays 0. Once its frame has been sent, `rsp_ready` is 1 until one reply byte is accepted.
- R7: The accepted reply byte is presented on `rd_data` with `rd_valid` = 1 and held until `rd_ready`. After that handshake, `in_ready` returns to 1.
- R8: A one-cycle `flush_req` with a non-empty buffer sends the buffered bytes as one frame. With an empty buffer, `flush_req` is ignored and no frame is sent.
- R9: `rsp_valid` is ignored while no read is outstanding. `rsp_ready` stays 0, and the ignored byte is never delivered on `rd_data`.
- R10: A read request arriving at an empty buffer is sent as a one-byte frame with both `out_sof` and `out_eof` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte offered |
| in_ready | output | 1 | Command byte can be taken |
| in_data | input | 8 | Command byte; bit 7 marks a read request |
| flush_req | input | 1 | Force out a partial frame |
| out_valid | output | 1 | Frame byte offered to the link |
| out_ready | input | 1 | Link takes the frame byte |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| rsp_valid | input | 1 | Reply byte from the link |
| rsp_ready | output | 1 | Reply byte can be taken |
| rsp_data | input | 8 | Reply byte |
| rd_valid | output | 1 | Reply byte offered to the producer |
| rd_ready | input | 1 | Producer takes the reply byte |
| rd_data | output | 8 | Reply byte to the producer |

## Verification
The hardest states to reach are a full-capacity frame under output back-pressure and a reply byte left waiting for the producer. The bench pushes exactly DEPTH write bytes, then drops `out_ready` in the first drain cycle to watch the head byte hold. For the reply case, it completes a read round trip with `rd_ready` held low and checks that input stays blocked. A stray reply offered while idle is followed by a real read, which shows that only the solicited byte is delivered.

// File: rtl/coalq_pkg.sv
package coalq_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_AWAIT = 2'd2,
    ST_HAND  = 2'd3
  } coalq_state_e;
endpackage

// File: rtl/coalq_store.sv
module coalq_store #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/coalq_reply.sv
module coalq_reply #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (take) begin
      hold_d = d_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign d_out = hold_q;
endmodule

// File: rtl/coalq_ctrl.sv
module coalq_ctrl
  import coalq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_is_rd,
  input  logic          flush_req,
  input  logic          out_ready,
  input  logic          rsp_valid,
  input  logic          rd_ready,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eof,
  output logic          rsp_ready,
  output logic          rsp_take,
  output logic          rd_valid
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  coalq_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ptr_q, ptr_d;
  logic          pend_q, pend_d;
  logic          accept;
  logic          last_out;

  assign in_ready  = (st_q == ST_FILL);
  assign accept    = in_valid && in_ready;
  assign wr_en     = accept;
  assign wr_addr   = cnt_q[AW-1:0];
  assign rd_addr   = ptr_q[AW-1:0];
  assign out_valid = (st_q == ST_DRAIN);
  assign last_out  = (ptr_q == (cnt_q - CNT_ONE));
  assign out_sof   = out_valid && (ptr_q == '0);
  assign out_eof   = out_valid && last_out;
  assign rsp_ready = (st_q == ST_AWAIT);
  assign rsp_take  = rsp_ready && rsp_valid;
  assign rd_valid  = (st_q == ST_HAND);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    pend_d = pend_q;
    unique case (st_q)
      ST_FILL: begin
        ptr_d = '0;
        if (accept) begin
          cnt_d = cnt_q + CNT_ONE;
          if (in_is_rd) begin
            pend_d = 1'b1;
            st_d   = ST_DRAIN;
          end else if ((cnt_q + CNT_ONE == CNT_FULL) || flush_req) begin
            st_d = ST_DRAIN;
          end
        end else if (flush_req && (cnt_q != '0)) begin
          st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (out_ready) begin
          if (last_out) begin
            cnt_d = '0;
            ptr_d = '0;
            st_d  = pend_q ? ST_AWAIT : ST_FILL;
          end else begin
            ptr_d = ptr_q + CNT_ONE;
          end
        end
      end
      ST_AWAIT: begin
        if (rsp_valid) begin
          pend_d = 1'b0;
          st_d   = ST_HAND;
        end
      end
      ST_HAND: begin
        if (rd_ready) begin
          st_d = ST_FILL;
        end
      end
      default: st_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FILL;
      cnt_q  <= '0;
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/coalq_cmd_queue.sv
module coalq_cmd_queue #(
  parameter int DEPTH  = 64,
  parameter int W      = 8,
  parameter int RD_BIT = 7,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         flush_req,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_sof,
  output logic         out_eof,
  input  logic         rsp_valid,
  output logic         rsp_ready,
  input  logic [W-1:0] rsp_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data
);
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          rsp_take;

  coalq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_is_rd  (in_data[RD_BIT]),
    .flush_req (flush_req),
    .out_ready (out_ready),
    .rsp_valid (rsp_valid),
    .rd_ready  (rd_ready),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .rsp_ready (rsp_ready),
    .rsp_take  (rsp_take),
    .rd_valid  (rd_valid)
  );

  coalq_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

  coalq_reply #(.W(W)) u_reply (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (rsp_take),
    .d_in  (rsp_data),
    .d_out (rd_data)
  );
endmodule

// File: rtl/coalq_chk.sv
module coalq_chk #(
  parameter int DEPTH  = 64,
  parameter int W      = 8,
  parameter int RD_BIT = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         flush_req,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_sof,
  input logic         out_eof,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_data,
  input logic         rd_valid,
  input logic         rd_ready,
  input logic [W-1:0] rd_data
);
  logic [15:0] sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
    end else if (out_valid && out_ready) begin
      sent_q <= out_eof ? 16'd0 : sent_q + 16'd1;
    end
  end

  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sent_q < 16'(DEPTH))); // R3
  AST_SOF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sof == (sent_q == 16'd0))); // R3
  AST_READ_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[RD_BIT]) |-> out_eof); // R4
  AST_DRAIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof))); // R5
  AST_READ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data[RD_BIT]) |=> !in_ready); // R6
  AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && !in_ready)); // R7
  AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (!in_ready && !out_valid && !rd_valid)); // R9
endmodule

bind coalq_cmd_queue coalq_chk #(.DEPTH(DEPTH), .W(W), .RD_BIT(RD_BIT)) u_chk (.*);

// File: tb/coalq_cmd_queue_bench.sv
module coalq_cmd_queue_bench;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, flush_req;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_sof, out_eof;
  logic [7:0] out_data;
  logic       rsp_valid, rsp_ready, rd_valid, rd_ready;
  logic [7:0] rsp_data, rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] lg_d [0:511];
  logic       lg_s [0:511];
  logic       lg_e [0:511];
  int lg_n = 0;

  always #5 clk = ~clk;

  coalq_cmd_queue #(.DEPTH(DEPTH)) u_coalq_cmd_queue (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .flush_req(flush_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      lg_d[lg_n] <= out_data;
      lg_s[lg_n] <= out_sof;
      lg_e[lg_n] <= out_eof;
      lg_n <= lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 300; i++) begin
      if (in_ready && !out_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic chk_frame(input int base, input int len, input string req);
    for (int k = 0; k < len; k++) begin
      chk(lg_s[base+k] == (k == 0), req, lg_s[base+k], k == 0);
      chk(lg_e[base+k] == (k == len-1), req, lg_e[base+k], k == len-1);
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(rd_valid == 1'b0, "R1", rd_valid, 0);
    chk(rsp_ready == 1'b0, "R1", rsp_ready, 0);
  endtask

  task automatic t_flush();
    int base;
    base = lg_n;
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    repeat (10) @(negedge clk);
    chk(lg_n == base && !out_valid, "R2", lg_n - base, 0);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    settle();
    chk(lg_n - base == 5, "R8", lg_n - base, 5);
    for (int i = 0; i < 5; i++)
      chk(lg_d[base+i] == 8'h10 + 8'(i), "R8", lg_d[base+i], 8'h10 + i);
    chk_frame(base, 5, "R8");
    base = lg_n;
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    repeat (5) @(negedge clk);
    chk(lg_n == base && in_ready, "R8", lg_n - base, 0);
  endtask

  task automatic t_full();
    int base;
    base = lg_n;
    for (int i = 0; i < DEPTH; i++) push(8'(i));
    out_ready = 1'b0;
    chk(out_valid && out_sof && out_data == 8'h00, "R5", out_data, 0);
    chk(!in_ready, "R5", in_ready, 0);
    repeat (3) @(negedge clk);
    chk(out_valid && out_sof && out_data == 8'h00, "R5", out_data, 0);
    out_ready = 1'b1;
    settle();
    chk(lg_n - base == DEPTH, "R3", lg_n - base, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      chk(lg_d[base+i] == 8'(i), "R3", lg_d[base+i], i);
    chk_frame(base, DEPTH, "R3");
  endtask

  task automatic read_round(input logic [7:0] cmd, input logic [7:0] reply, input int pre,
                            input string req);
    int base;
    base = lg_n;
    for (int i = 0; i < pre; i++) push(8'h20 + 8'(i));
    push(cmd);
    for (int i = 0; i < 100; i++) begin
      if (rsp_ready) break;
      @(negedge clk);
    end
    chk(lg_n - base == pre + 1, req, lg_n - base, pre + 1);
    chk(lg_d[base+pre] == cmd, req, lg_d[base+pre], cmd);
    chk_frame(base, pre + 1, req);
    chk(rsp_ready && !in_ready, "R6", rsp_ready, 1);
    rsp_valid = 1'b1;
    rsp_data  = reply;
    @(negedge clk);
    rsp_valid = 1'b0;
    rsp_data  = 8'hEE;
    repeat (3) @(negedge clk);
    chk(rd_valid && rd_data == reply, "R7", rd_data, reply);
    chk(!in_ready && !rsp_ready, "R7", in_ready, 0);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    chk(in_ready && !rd_valid, "R7", in_ready, 1);
  endtask

  task automatic t_stray();
    rsp_valid = 1'b1;
    rsp_data  = 8'h99;
    @(negedge clk);
    chk(!rsp_ready && !rd_valid, "R9", rsp_ready, 0);
    repeat (2) @(negedge clk);
    rsp_valid = 1'b0;
    chk(!rd_valid && in_ready, "R9", rd_valid, 0);
    read_round(8'h81, 8'h42, 0, "R9");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; flush_req = 1'b0;
    out_ready = 1'b1; rsp_valid = 1'b0; rsp_data = '0; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flush();
    t_full();
    read_round(8'h85, 8'h3C, 3, "R4");
    read_round(8'h80, 8'h5A, 0, "R10");
    t_stray();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule